// File: doc/BRIEF.md
# Burst Column Address Generator

This block walks a memory row column by column for one burst. A start strobe loads a start column, a length code and an ordering select. From the next clock on, the block puts one column address per cycle on its output and raises a valid flag with it. A fixed-length burst of 1, 2, 4 or 8 addresses stays inside the aligned window that holds the start column, and a done flag marks its last address. In page mode the address steps through the whole row and keeps wrapping until a stop or a clear arrives.

The ordering is either a linear count that wraps inside the window or an interleaved one. In the interleaved order, the low bits of the start column are XORed with the beat index. A new start is taken on any cycle, including the cycle of the last beat, and it replaces the running burst at once. Stop ends a burst early and leaves the last address on the output. Clear ends it and returns the address to zero.

Top module: `burst_col_gen`

## Requirements
- R1: While reset is asserted and just after it, valid_o and done_o are 0 and col_o is 0.
- R2: On the cycle after start_i is high (clear_i low), col_o equals the col_i sampled with it and valid_o is 1.
- R3: Length codes on len_i: 3'b000 gives 1 beat, 3'b001 gives 2, 3'b010 gives 4, 3'b011 gives 8, and any code with bit 2 set selects page mode. With ilv_i = 0 and a fixed length N, beat k (k = 0 for the first beat, one beat per cycle) has the start column's bits above log2(N) unchanged and its low log2(N) bits equal to (start + k) mod N.
- R4: With ilv_i = 1 and a fixed length N, beat k is the start column with its low log2(N) bits XORed with k.
- R5: In page mode, beat k is (start + k) mod 256 whatever ilv_i was. The burst runs until stop_i or clear_i and never raises done_o.
- R6: done_o is 1 only together with valid_o, and only on the last beat of a fixed-length burst. If no new start arrives on that cycle, valid_o is 0 on the cycle after it.
- R7: stop_i with start_i and clear_i low makes valid_o and done_o 0 on the next cycle and leaves col_o at its last value. A stop while idle changes nothing.
- R8: clear_i makes valid_o and done_o 0 and col_o 0 on the next cycle, and it overrides a start_i in the same cycle.
- R9: A start during a running burst, including on its last beat or together with stop_i, begins the new burst on the next cycle with the new column, length and order.
- R10: While idle, valid_o stays 0 and col_o holds its last value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a burst at col_i |
| col_i | input | 8 | Start column |
| len_i | input | 3 | Burst length code |
| ilv_i | input | 1 | 1 = interleaved order, 0 = sequential |
| stop_i | input | 1 | End the running burst, hold the address |
| clear_i | input | 1 | End the burst and return the address to 0 |
| col_o | output | 8 | Current column address |
| valid_o | output | 1 | col_o is a burst beat |
| done_o | output | 1 | This beat is the last of a fixed burst |

## Verification
Three strobes can land in the same cycle as a running burst's step: a start can fall on the beat that raises done, and a start can also come together with stop or with clear. The bench raises a start exactly on the sampled last beat, in the middle of a burst, together with a stop and together with a clear. In each case it then follows the next cycles' addresses against the arithmetic ordering of the winning command. Clear must beat start, and start must beat both stop and the normal end of the burst.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;
  // Length code encoding; codes with bit 2 set all select page mode.
  typedef enum logic [2:0] {
    BL_ONE   = 3'b000,
    BL_TWO   = 3'b001,
    BL_FOUR  = 3'b010,
    BL_EIGHT = 3'b011,
    BL_PAGE  = 3'b100
  } blen_e;

  localparam int unsigned LEN_CODE_W = 3;
  localparam int unsigned MAX_WIN_LOG = 3;
endpackage

// File: rtl/burst_rst_sync.sv
module burst_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      hold_q <= meta_q;
    end
  end

  assign rst_sync_n = hold_q;
endmodule

// File: rtl/burst_len_dec.sv
module burst_len_dec
  import burst_col_pkg::*;
#(
  parameter int unsigned COL_W = 8
) (
  input  logic [LEN_CODE_W-1:0] code_i,
  output logic [COL_W-1:0]      mask_o,
  output logic                  page_o
);
  assign page_o = code_i[2];

  // Window mask: ones over the bits that move inside the burst window.
  for (genvar g = 0; g < COL_W; g++) begin : g_mask
    if (g < MAX_WIN_LOG) begin : g_low
      assign mask_o[g] = page_o | (code_i[1:0] > 2'(g));
    end else begin : g_high
      assign mask_o[g] = page_o;
    end
  end
endmodule

// File: rtl/burst_col_step.sv
module burst_col_step #(
  parameter int unsigned COL_W = 8
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] idx_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             ilv_i,
  output logic [COL_W-1:0] addr_o
);
  logic [COL_W-1:0] sum;
  logic [COL_W-1:0] seq_addr;
  logic [COL_W-1:0] xor_addr;

  always_comb begin
    sum      = base_i + idx_i;
    seq_addr = (base_i & ~mask_i) | (sum & mask_i);
    xor_addr = base_i ^ (idx_i & mask_i);
    addr_o   = ilv_i ? xor_addr : seq_addr;
  end
endmodule

// File: rtl/burst_col_ctrl.sv
module burst_col_ctrl
  import burst_col_pkg::*;
#(
  parameter int unsigned COL_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic [COL_W-1:0]      col_i,
  input  logic [LEN_CODE_W-1:0] len_i,
  input  logic                  ilv_i,
  input  logic                  stop_i,
  input  logic                  clear_i,
  input  logic [COL_W-1:0]      in_mask_i,
  input  logic                  in_page_i,
  input  logic [COL_W-1:0]      run_mask_i,
  input  logic                  run_page_i,
  input  logic [COL_W-1:0]      step_addr_i,
  output logic [COL_W-1:0]      base_o,
  output logic [COL_W-1:0]      idx_o,
  output logic [LEN_CODE_W-1:0] len_o,
  output logic                  ilv_o,
  output logic [COL_W-1:0]      col_o,
  output logic                  valid_o,
  output logic                  done_o
);
  logic [COL_W-1:0]      base_q, base_d;
  logic [COL_W-1:0]      idx_q,  idx_d;
  logic [LEN_CODE_W-1:0] len_q,  len_d;
  logic                  ilv_q,  ilv_d;
  logic [COL_W-1:0]      col_q,  col_d;
  logic                  act_q,  act_d;
  logic                  done_q, done_d;
  logic                  load_en;
  logic                  step_en;
  logic                  col_en;

  // Priority: clear, then start, then stop, then normal stepping.
  always_comb begin
    load_en = start_i & ~clear_i;
    step_en = ~clear_i & ~start_i & ~stop_i & act_q & ~done_q;
    col_en  = clear_i | load_en | step_en;

    base_d = col_i;
    len_d  = len_i;
    ilv_d  = ilv_i;
    idx_d  = load_en ? COL_W'(1) : idx_q + COL_W'(1);
    col_d  = clear_i ? '0 : (load_en ? col_i : step_addr_i);

    if (clear_i) begin
      act_d  = 1'b0;
      done_d = 1'b0;
    end else if (start_i) begin
      act_d  = 1'b1;
      done_d = ~in_page_i & (in_mask_i == '0);
    end else if (stop_i) begin
      act_d  = 1'b0;
      done_d = 1'b0;
    end else if (act_q && !done_q) begin
      act_d  = 1'b1;
      done_d = ~run_page_i & (idx_q == run_mask_i);
    end else begin
      act_d  = 1'b0;
      done_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      len_q  <= '0;
      ilv_q  <= 1'b0;
    end else if (load_en) begin
      base_q <= base_d;
      len_q  <= len_d;
      ilv_q  <= ilv_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (load_en || step_en) begin
      idx_q <= idx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q <= '0;
    end else if (col_en) begin
      col_q <= col_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      act_q  <= act_d;
      done_q <= done_d;
    end
  end

  assign base_o  = base_q;
  assign idx_o   = idx_q;
  assign len_o   = len_q;
  assign ilv_o   = ilv_q;
  assign col_o   = col_q;
  assign valid_o = act_q;
  assign done_o  = done_q;
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import burst_col_pkg::*;
#(
  parameter int unsigned COL_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic [COL_W-1:0]      col_i,
  input  logic [LEN_CODE_W-1:0] len_i,
  input  logic                  ilv_i,
  input  logic                  stop_i,
  input  logic                  clear_i,
  output logic [COL_W-1:0]      col_o,
  output logic                  valid_o,
  output logic                  done_o
);
  logic                  rst_sync_n;
  logic [COL_W-1:0]      in_mask;
  logic                  in_page;
  logic [COL_W-1:0]      run_mask;
  logic                  run_page;
  logic [COL_W-1:0]      base_q;
  logic [COL_W-1:0]      idx_q;
  logic [LEN_CODE_W-1:0] len_q;
  logic                  ilv_q;
  logic                  ilv_eff;
  logic [COL_W-1:0]      step_addr;

  burst_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  burst_len_dec #(.COL_W(COL_W)) u_dec_in (
    .code_i (len_i),
    .mask_o (in_mask),
    .page_o (in_page)
  );

  burst_len_dec #(.COL_W(COL_W)) u_dec_run (
    .code_i (len_q),
    .mask_o (run_mask),
    .page_o (run_page)
  );

  // Page mode always counts linearly through the row.
  assign ilv_eff = ilv_q & ~run_page;

  burst_col_step #(.COL_W(COL_W)) u_step (
    .base_i (base_q),
    .idx_i  (idx_q),
    .mask_i (run_mask),
    .ilv_i  (ilv_eff),
    .addr_o (step_addr)
  );

  burst_col_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .start_i     (start_i),
    .col_i       (col_i),
    .len_i       (len_i),
    .ilv_i       (ilv_i),
    .stop_i      (stop_i),
    .clear_i     (clear_i),
    .in_mask_i   (in_mask),
    .in_page_i   (in_page),
    .run_mask_i  (run_mask),
    .run_page_i  (run_page),
    .step_addr_i (step_addr),
    .base_o      (base_q),
    .idx_o       (idx_q),
    .len_o       (len_q),
    .ilv_o       (ilv_q),
    .col_o       (col_o),
    .valid_o     (valid_o),
    .done_o      (done_o)
  );
endmodule

// File: rtl/burst_col_chk.sv
module burst_col_chk #(
  parameter int unsigned COL_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic [COL_W-1:0] col_i,
  input logic             stop_i,
  input logic             clear_i,
  input logic [COL_W-1:0] col_o,
  input logic             valid_o,
  input logic             done_o
);
  // R2
  start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !clear_i) |=> (valid_o && col_o == $past(col_i)));

  // R6
  done_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> valid_o);

  // R6
  done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i && !clear_i) |=> !valid_o);

  // R7
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && !start_i && !clear_i) |=> (!valid_o && !done_o && $stable(col_o)));

  // R8
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (!valid_o && !done_o && col_o == '0));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid_o && !start_i && !clear_i) |=> (!valid_o && $stable(col_o)));

  // R3
  run_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !done_o && !stop_i && !clear_i) |=> valid_o);
endmodule

bind burst_col_gen burst_col_chk #(.COL_W(COL_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .start_i (start_i),
  .col_i   (col_i),
  .stop_i  (stop_i),
  .clear_i (clear_i),
  .col_o   (col_o),
  .valid_o (valid_o),
  .done_o  (done_o)
);

// File: tb/test_burst_col_gen.sv
`timescale 1ns/1ps
module test_burst_col_gen;
  logic       clk;
  logic       rst_n;
  logic       start_i;
  logic [7:0] col_i;
  logic [2:0] len_i;
  logic       ilv_i;
  logic       stop_i;
  logic       clear_i;
  logic [7:0] col_o;
  logic       valid_o;
  logic       done_o;

  int n_chk;
  int n_fail;

  burst_col_gen i_burst_col_gen (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .col_i   (col_i),
    .len_i   (len_i),
    .ilv_i   (ilv_i),
    .stop_i  (stop_i),
    .clear_i (clear_i),
    .col_o   (col_o),
    .valid_o (valid_o),
    .done_o  (done_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Advance one clock; sample and drive 1 ns after the rising edge.
  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  function automatic logic [7:0] exp_addr(input logic [7:0] base, input logic [2:0] code,
                                          input logic ilv, input int k);
    logic [7:0] m;
    logic [7:0] kk;
    kk = 8'(k);
    if (code[2]) return base + kk;
    m = 8'((1 << code[1:0]) - 1);
    if (ilv) return base ^ (kk & m);
    return (base & ~m) | ((base + kk) & m);
  endfunction

  task automatic go(input logic [7:0] c, input logic [2:0] l, input logic iv);
    start_i = 1'b1; col_i = c; len_i = l; ilv_i = iv;
    cyc();
    start_i = 1'b0;
  endtask

  initial begin
    #2000000;
    n_chk++;
    n_fail++;
    $display("FAIL R2 watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; start_i = 1'b0; col_i = '0; len_i = '0; ilv_i = 1'b0;
    stop_i = 1'b0; clear_i = 1'b0;
    #23;
    chk("R1 valid in reset", int'(valid_o), 0);
    chk("R1 done in reset", int'(done_o), 0);
    chk("R1 col in reset", int'(col_o), 0);
    rst_n = 1'b1;
    repeat (4) cyc();
    chk("R1 valid after reset", int'(valid_o), 0);
    chk("R1 col after reset", int'(col_o), 0);

    // R7: stop while idle has no effect
    stop_i = 1'b1; cyc(); stop_i = 1'b0;
    chk("R7 idle stop valid", int'(valid_o), 0);
    chk("R7 idle stop col", int'(col_o), 0);

    // R3 R4 R6: every start column, each fixed length, both orders
    for (int code = 0; code < 4; code++) begin
      for (int iv = 0; iv < 2; iv++) begin
        for (int b = 0; b < 256; b++) begin
          int n;
          n = 1 << code;
          go(8'(b), 3'(code), iv[0]);
          for (int k = 0; k < n; k++) begin
            chk(iv != 0 ? "R4 valid" : "R3 valid", int'(valid_o), 1);
            chk(iv != 0 ? "R4 addr" : "R3 addr", int'(col_o),
                int'(exp_addr(8'(b), 3'(code), iv[0], k)));
            chk("R6 done", int'(done_o), (k == n - 1) ? 1 : 0);
            cyc();
          end
          chk("R6 valid after last", int'(valid_o), 0);
          chk("R10 idle col holds", int'(col_o), int'(exp_addr(8'(b), 3'(code), iv[0], n - 1)));
          cyc();
          chk("R10 idle valid", int'(valid_o), 0);
        end
      end
    end

    // R5: page mode wraps through 256 and runs until stop
    for (int s = 0; s < 3; s++) begin
      for (int iv = 0; iv < 2; iv++) begin
        logic [7:0] b;
        logic [2:0] code;
        b = (s == 0) ? 8'h00 : (s == 1) ? 8'h37 : 8'hFF;
        code = (iv != 0) ? 3'b111 : 3'b100;
        go(b, code, iv[0]);
        for (int k = 0; k < 300; k++) begin
          chk("R5 valid", int'(valid_o), 1);
          chk("R5 addr", int'(col_o), int'(exp_addr(b, 3'b100, 1'b0, k)));
          chk("R5 no done", int'(done_o), 0);
          if (k == 299) stop_i = 1'b1;
          cyc();
          stop_i = 1'b0;
        end
        chk("R7 stop valid", int'(valid_o), 0);
        chk("R7 stop col", int'(col_o), int'(exp_addr(b, 3'b100, 1'b0, 299)));
        cyc();
      end
    end

    // R7: stop in the middle of a fixed burst
    go(8'h40, 3'b011, 1'b0);
    cyc();
    chk("R7 mid addr", int'(col_o), 8'h41);
    stop_i = 1'b1; cyc(); stop_i = 1'b0;
    chk("R7 mid stop valid", int'(valid_o), 0);
    chk("R7 mid stop done", int'(done_o), 0);
    chk("R7 mid stop col", int'(col_o), 8'h41);

    // R9: restart mid-burst with a new column, length and order
    go(8'h12, 3'b011, 1'b0);
    cyc(); cyc();
    chk("R9 pre addr", int'(col_o), 8'h14);
    go(8'h85, 3'b010, 1'b1);
    for (int k = 0; k < 4; k++) begin
      chk("R9 restart addr", int'(col_o), int'(8'h85 ^ 8'(k)));
      chk("R9 restart done", int'(done_o), (k == 3) ? 1 : 0);
      if (k == 3) begin
        // R9: start on the last beat continues without a gap
        start_i = 1'b1; col_i = 8'hFE; len_i = 3'b001; ilv_i = 1'b0;
      end
      cyc();
      start_i = 1'b0;
    end
    chk("R9 back-to-back valid", int'(valid_o), 1);
    chk("R9 back-to-back addr0", int'(col_o), 8'hFE);
    cyc();
    chk("R9 back-to-back addr1", int'(col_o), 8'hFF);
    chk("R9 back-to-back done", int'(done_o), 1);
    cyc();

    // R9: start and stop together, start wins
    go(8'h20, 3'b100, 1'b0);
    cyc();
    start_i = 1'b1; stop_i = 1'b1; col_i = 8'h9A; len_i = 3'b000;
    cyc();
    start_i = 1'b0; stop_i = 1'b0;
    chk("R9 start over stop valid", int'(valid_o), 1);
    chk("R9 start over stop addr", int'(col_o), 8'h9A);
    chk("R9 start over stop done", int'(done_o), 1);
    cyc();
    chk("R6 single beat ends", int'(valid_o), 0);

    // R8: clear mid-burst, and clear over start
    go(8'h77, 3'b100, 1'b0);
    cyc();
    clear_i = 1'b1; cyc(); clear_i = 1'b0;
    chk("R8 clear valid", int'(valid_o), 0);
    chk("R8 clear col", int'(col_o), 0);
    chk("R8 clear done", int'(done_o), 0);
    start_i = 1'b1; clear_i = 1'b1; col_i = 8'h55; len_i = 3'b011;
    cyc();
    start_i = 1'b0; clear_i = 1'b0;
    chk("R8 clear over start valid", int'(valid_o), 0);
    chk("R8 clear over start col", int'(col_o), 0);
    cyc();
    chk("R10 after clear valid", int'(valid_o), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule